// File: doc/BRIEF.md
# PCI Clock Run Controller

This block is the host end of the PCI clock-run handshake, which lets the system stop the PCI clock when nothing needs it and start it again on demand. It watches three activity sources: PCI or LPC bus cycles, internal requests that must reach the PCI bus, and serial interrupt activity. Once none of them has been seen for a programmable number of clocks (29 by default), it offers to stop the clock. It drives the shared open-drain request line high for one clock and then releases it. Peripherals then get a short window to pull the line low again and keep the clock running.

If nobody claims the line, the block stops the clock. In external distribution mode it raises a stop request to the clock generator. In internal distribution mode it drops its own gate enable and never raises the stop request. While the clock is stopped, a peripheral pulling the line low or an internal bus request wakes the block. It releases the stop and drives the line low again, and the idle count starts over. The request line is modelled as three signals: an output enable, an output value and a sampled input. The sampled input passes through a two-flop synchronizer. The block runs from a free-running clock that the stop request does not affect.

Top module: `pci_clk_run_ctrl`

## Requirements
- R1: During and after reset the line is driven low (oe=1, value=0), `clk_stop_o` is 0 and `clk_gate_en_o` is 1.
- R2: After IDLE_CYC (29) consecutive clocks with all three activity inputs low, the block drives the line high (oe=1, value=1) for exactly one clock and then releases it (oe=0). The high cycle is always preceded by a driven-low cycle.
- R3: A pulse on any one activity input while the line is driven low restarts the idle count from zero.
- R4: Activity seen during the high cycle or the release window returns the block to driving the line low on the next clock, and the idle count restarts.
- R5: An internal bus request makes the block drive the line low one clock after it is sampled, whatever the current phase.
- R6: If the synchronized line reads low during the release window, the block resumes driving the line low and does not stop the clock. A low level placed on the pin up to the third clock after the high cycle is caught.
- R7: If no low level is seen within WIN_CYC (6) clocks counted from the start of the high cycle, `clk_stop_o` rises in external mode (`int_dist_i`=0), and the line stays released while stopped.
- R8: With `int_dist_i`=1 the block stops the clock by driving `clk_gate_en_o` to 0 and never raises `clk_stop_o`. With `int_dist_i`=0, `clk_gate_en_o` stays 1.
- R9: While stopped, a synchronized low on the line or an internal request clears the stop, re-enables the gate and drives the line low. A full IDLE_CYC idle period is then needed before the next offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running PCI-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cyc_i | input | 1 | A PCI or LPC bus cycle is in progress |
| int_req_i | input | 1 | An internal device needs the PCI bus |
| irq_act_i | input | 1 | Serial interrupt activity |
| int_dist_i | input | 1 | 1: clock distributed internally (gate), 0: external generator (stop request) |
| run_pin_i | input | 1 | Sampled level of the clock-run line |
| run_pin_oe_o | output | 1 | Output enable for the clock-run line |
| run_pin_val_o | output | 1 | Value driven when enabled (0 = request clock) |
| clk_stop_o | output | 1 | Stop request to the external clock generator |
| clk_gate_en_o | output | 1 | Enable for the internal clock gate |

## Verification
The checker watches the per-cycle invariants on every clock. The high drive lasts a single cycle and always follows a driven-low cycle. An internal request forces a driven low on the next clock. The stop request only appears while the line is released, never appears in internal mode, and is cleared by an internal request. The exact cycle counts need the bench's scripted scenarios: the 29-clock idle period, the restart caused by each activity source, and the six-clock window. The same goes for the boundary where a late peripheral pull is caught just in time or just after the stop, and for wake-up followed by a fresh full idle period.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    // Phases of the clock-run handshake
    typedef enum logic [1:0] {
        ST_DRIVE_LO = 2'd0,  // line held low, clock running, idle count active
        ST_DRIVE_HI = 2'd1,  // single cycle of active high drive
        ST_FLOAT    = 2'd2,  // line released, waiting for a peripheral claim
        ST_HALTED   = 2'd3   // clock stopped
    } pcr_state_e;

endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
    parameter int STAGES = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pcr_fsm.sv
module pcr_fsm
    import pcr_pkg::*;
#(
    parameter int IDLE_CYC = 29,
    parameter int WIN_CYC  = 6,
    parameter int BLANK    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       wake_req_i,
    input  logic       pin_low_i,
    output pcr_state_e state_o
);

    localparam int IW = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
    localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);
    localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_CYC - 2);
    localparam logic [WW-1:0] WIN_BLANK = WW'(BLANK);

    typedef struct packed {
        pcr_state_e    st;
        logic [IW-1:0] idle;
        logic [WW-1:0] win;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_DRIVE_LO: begin
                r_d.win = '0;
                if (busy_i) begin
                    r_d.idle = '0;
                end else if (r_q.idle == IDLE_LAST) begin
                    r_d.idle = '0;
                    r_d.st   = ST_DRIVE_HI;
                end else begin
                    r_d.idle = r_q.idle + 1'b1;
                end
            end
            ST_DRIVE_HI: begin
                r_d.win = '0;
                r_d.st  = busy_i ? ST_DRIVE_LO : ST_FLOAT;
            end
            ST_FLOAT: begin
                if (busy_i || (r_q.win >= WIN_BLANK && pin_low_i)) begin
                    r_d.st  = ST_DRIVE_LO;
                    r_d.win = '0;
                end else if (r_q.win == WIN_LAST) begin
                    r_d.st  = ST_HALTED;
                    r_d.win = '0;
                end else begin
                    r_d.win = r_q.win + 1'b1;
                end
            end
            ST_HALTED: begin
                if (wake_req_i || pin_low_i) r_d.st = ST_DRIVE_LO;
            end
            default: r_d.st = ST_DRIVE_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_DRIVE_LO;
            r_q.idle <= '0;
            r_q.win  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

endmodule

// File: rtl/pcr_outdec.sv
module pcr_outdec
    import pcr_pkg::*;
(
    input  pcr_state_e state_i,
    input  logic       int_dist_i,
    output logic       oe_o,
    output logic       val_o,
    output logic       stop_o,
    output logic       gate_en_o
);

    always_comb begin
        oe_o      = 1'b0;
        val_o     = 1'b0;
        stop_o    = 1'b0;
        gate_en_o = 1'b1;
        unique case (state_i)
            ST_DRIVE_LO: oe_o = 1'b1;
            ST_DRIVE_HI: begin
                oe_o  = 1'b1;
                val_o = 1'b1;
            end
            ST_FLOAT: ;
            ST_HALTED: begin
                stop_o    = !int_dist_i;
                gate_en_o = !int_dist_i;
            end
            default: oe_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pci_clk_run_ctrl.sv
module pci_clk_run_ctrl
    import pcr_pkg::*;
#(
    parameter int IDLE_CYC    = 29,
    parameter int WIN_CYC     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cyc_i,
    input  logic int_req_i,
    input  logic irq_act_i,
    input  logic int_dist_i,
    input  logic run_pin_i,
    output logic run_pin_oe_o,
    output logic run_pin_val_o,
    output logic clk_stop_o,
    output logic clk_gate_en_o
);

    // The synchronizer output lags the pin; the first window cycles still
    // show the level from before the high drive and must be ignored.
    localparam int BLANK = SYNC_STAGES - 1;

    logic       pin_sync;
    logic       busy;
    pcr_state_e state;

    assign busy = bus_cyc_i | int_req_i | irq_act_i;

    pcr_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (run_pin_i),
        .sync_o  (pin_sync)
    );

    pcr_fsm #(
        .IDLE_CYC (IDLE_CYC),
        .WIN_CYC  (WIN_CYC),
        .BLANK    (BLANK)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy),
        .wake_req_i (int_req_i),
        .pin_low_i  (!pin_sync),
        .state_o    (state)
    );

    pcr_outdec u_dec (
        .state_i    (state),
        .int_dist_i (int_dist_i),
        .oe_o       (run_pin_oe_o),
        .val_o      (run_pin_val_o),
        .stop_o     (clk_stop_o),
        .gate_en_o  (clk_gate_en_o)
    );

endmodule

// File: rtl/pcr_chk.sv
module pcr_chk (
    input logic clk,
    input logic rst_n,
    input logic int_req_i,
    input logic int_dist_i,
    input logic run_pin_oe_o,
    input logic run_pin_val_o,
    input logic clk_stop_o,
    input logic clk_gate_en_o
);

    // R2: the high drive lasts one clock only
    assert_hi_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_pin_oe_o && run_pin_val_o) |=> !(run_pin_oe_o && run_pin_val_o));

    // R2: the high drive follows a driven-low cycle
    assert_hi_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_pin_oe_o && run_pin_val_o) |-> $past(run_pin_oe_o && !run_pin_val_o));

    // R5: an internal request forces a low drive on the next clock
    assert_int_req_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_i |=> (run_pin_oe_o && !run_pin_val_o));

    // R7: while stopped the line is released
    assert_stop_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_o |-> !run_pin_oe_o);

    // R8: internal distribution never raises the stop request
    assert_int_no_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_dist_i |-> !clk_stop_o);

    // R8: external distribution keeps the gate open
    assert_ext_gate_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_dist_i |-> clk_gate_en_o);

    // R9: an internal request clears a stop
    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_o && int_req_i) |=> !clk_stop_o);

endmodule

bind pci_clk_run_ctrl pcr_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .int_req_i     (int_req_i),
    .int_dist_i    (int_dist_i),
    .run_pin_oe_o  (run_pin_oe_o),
    .run_pin_val_o (run_pin_val_o),
    .clk_stop_o    (clk_stop_o),
    .clk_gate_en_o (clk_gate_en_o)
);

// File: tb/pci_clk_run_ctrl_tb_top.sv
`timescale 1ns/1ps
module pci_clk_run_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_cyc = 1'b0, int_req = 1'b0, irq_act = 1'b0, int_dist = 1'b0;
    logic pull = 1'b0;
    logic pin, oe, val, stop, gate;
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;

    typedef struct {
        int    at;
        logic  oe, val, stop, gate;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // open-drain line with pull-up; a peripheral may pull it low
    assign pin = oe ? val : !pull;

    pci_clk_run_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_cyc_i     (bus_cyc),
        .int_req_i     (int_req),
        .irq_act_i     (irq_act),
        .int_dist_i    (int_dist),
        .run_pin_i     (pin),
        .run_pin_oe_o  (oe),
        .run_pin_val_o (val),
        .clk_stop_o    (stop),
        .clk_gate_en_o (gate)
    );

    // ---------------- driver helpers ----------------
    task automatic push(input int at, input logic e_oe, input logic e_val,
                        input logic e_stop, input logic e_gate, input string tag);
        exp_t it;
        it.at = at; it.oe = e_oe; it.val = e_val; it.stop = e_stop;
        it.gate = e_gate; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_low(input int at, input string tag);
        push(at, 1'b1, 1'b0, 1'b0, 1'b1, tag);
    endtask
    task automatic exp_hi(input int at, input string tag);
        push(at, 1'b1, 1'b1, 1'b0, 1'b1, tag);
    endtask
    task automatic exp_rel(input int at, input string tag);
        push(at, 1'b0, 1'b0, 1'b0, 1'b1, tag);
    endtask
    task automatic exp_halt(input int at, input string tag);
        push(at, 1'b0, 1'b0, 1'b1, 1'b1, tag);
    endtask
    task automatic exp_gated(input int at, input string tag);
        push(at, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // one bus pulse, then 29 idle clocks; returns the cycle of the high drive
    task automatic offer(output int t);
        int c0;
        @(negedge clk);
        c0 = cyc;
        bus_cyc = 1'b1;
        wait_to(c0 + 1);
        bus_cyc = 1'b0;
        exp_low(c0 + 29, "R2 low before offer");
        exp_hi(c0 + 30, "R2 high drive");
        wait_to(c0 + 30);
        t = c0 + 30;
    endtask

    task automatic count_restart(input bit use_int);
        int c0;
        @(negedge clk);
        c0 = cyc;
        bus_cyc = 1'b1;
        wait_to(c0 + 1);
        bus_cyc = 1'b0;
        wait_to(c0 + 20);
        if (use_int) int_req = 1'b1; else irq_act = 1'b1;
        exp_low(c0 + 21, use_int ? "R5 int req low" : "R3 irq low");
        wait_to(c0 + 21);
        int_req = 1'b0; irq_act = 1'b0;
        exp_low(c0 + 30, "R3 count restarted");
        exp_low(c0 + 49, "R3 still counting");
        exp_hi(c0 + 50, "R3 offer after restart");
        wait_to(c0 + 50);
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (it.at < cyc) begin
                n_fail++;
                $display("FAIL %s: item for cycle %0d missed (now %0d)", it.tag, it.at, cyc);
            end else if (oe !== it.oe || val !== it.val || stop !== it.stop || gate !== it.gate) begin
                n_fail++;
                $display("FAIL %s @%0d: oe/val/stop/gate actual %b%b%b%b expected %b%b%b%b",
                         it.tag, cyc, oe, val, stop, gate, it.oe, it.val, it.stop, it.gate);
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int t;
        wait_to(2);
        exp_low(3, "R1 reset state");
        wait_to(4);
        rst_n = 1'b1;
        exp_low(5, "R1 after reset");

        // R7 stop, then R9 wake by peripheral pull
        offer(t);
        exp_rel(t + 1, "R2 release");
        exp_rel(t + 5, "R7 window open");
        exp_halt(t + 6, "R7 stop");
        exp_halt(t + 10, "R7 stays stopped");
        wait_to(t + 10);
        pull = 1'b1;
        exp_halt(t + 12, "R9 sync latency");
        exp_low(t + 13, "R9 wake by pin");
        wait_to(t + 13);
        pull = 1'b0;
        exp_low(t + 41, "R9 idle restarted");
        exp_hi(t + 42, "R9 next offer");
        wait_to(t + 42);

        // R6 early claim
        offer(t);
        exp_rel(t + 1, "R2 release");
        wait_to(t + 2);
        pull = 1'b1;
        exp_rel(t + 4, "R6 sync latency");
        exp_low(t + 5, "R6 claim seen");
        wait_to(t + 5);
        pull = 1'b0;
        exp_low(t + 10, "R6 clock kept");
        wait_to(t + 10);

        // R6 latest claim that is still caught
        offer(t);
        wait_to(t + 3);
        pull = 1'b1;
        exp_rel(t + 5, "R6 late window");
        exp_low(t + 6, "R6 late claim caught");
        wait_to(t + 6);
        pull = 1'b0;
        exp_low(t + 12, "R6 no stop");
        wait_to(t + 12);

        // R7 claim one clock too late: stop then immediate wake
        offer(t);
        wait_to(t + 4);
        pull = 1'b1;
        exp_halt(t + 6, "R7 claim too late");
        exp_low(t + 7, "R9 wake after late claim");
        wait_to(t + 7);
        pull = 1'b0;

        // R4 bus activity during the window
        offer(t);
        wait_to(t + 2);
        bus_cyc = 1'b1;
        exp_low(t + 3, "R4 abort in window");
        wait_to(t + 3);
        bus_cyc = 1'b0;
        exp_low(t + 31, "R4 count restarted");
        exp_hi(t + 32, "R4 next offer");
        wait_to(t + 32);

        // R4 irq activity during the high cycle
        offer(t);
        irq_act = 1'b1;
        exp_low(t + 1, "R4 abort in high cycle");
        wait_to(t + 1);
        irq_act = 1'b0;
        exp_hi(t + 30, "R4 offer after abort");
        wait_to(t + 30);

        // R3 each source restarts the count
        count_restart(1'b0);
        count_restart(1'b1);

        // R5 internal request from the window
        offer(t);
        wait_to(t + 2);
        int_req = 1'b1;
        exp_low(t + 3, "R5 int req in window");
        wait_to(t + 3);
        int_req = 1'b0;

        // R8 internal distribution mode
        @(negedge clk);
        int_dist = 1'b1;
        offer(t);
        exp_rel(t + 1, "R8 release");
        exp_gated(t + 6, "R8 gate off no stop");
        exp_gated(t + 8, "R8 stays gated");
        wait_to(t + 8);
        int_req = 1'b1;
        exp_low(t + 9, "R8 R5 wake by int req");
        wait_to(t + 9);
        int_req = 1'b0;
        int_dist = 1'b0;

        repeat (5) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule